// File: doc/BRIEF.md
# Strided Vector Address Sequencer with Strip Splitting

This block turns one request for a strided vector memory access of any total length into a stream of element addresses. The request gives a start address, a stride, and an element count. The vector register holds at most `MAX_VL` elements (64 by default), so the block splits the access into strips. The short remainder strip comes first. Every strip after it has the full length. The address keeps advancing by the stride across strip boundaries, so element k always lands at start + k × stride. A stride of 1 walks contiguous words. A larger stride walks a column of a row-major array.

Each element is presented with its address, its index inside the current strip, and that strip's length. A flag marks the first element of each strip, so a downstream unit can load its vector-length register with the value carried there. The stream uses a valid/ready handshake, and the consumer can stall it at any time. When the last element has been accepted, the block pulses a completion signal. A request with a zero count completes without producing any element.

Top module: `strip_addr_seq`

## Requirements
- R1: After reset, `elem_valid_o` and `done_o` are low.
- R2: A request with `total_i` = 0 produces no element. `done_o` is high for exactly the one cycle after the start cycle.
- R3: For an accepted request, `elem_valid_o` rises in the cycle after `start_i`. The k-th element presented (k counted from 0) carries address `base_i + k*stride_i` modulo 2^`ADDR_W`. Exactly `total_i` elements are presented.
- R4: The first strip has `total_i mod MAX_VL` elements when that remainder is non-zero, and `MAX_VL` elements otherwise. Every later strip has `MAX_VL` elements, so no strip has zero length. `strip_len_o` shows the current strip's length on every valid element.
- R5: `elem_idx_o` counts 0 to length−1 inside each strip. `strip_start_o` is high exactly when `elem_valid_o` is high and `elem_idx_o` is 0.
- R6: The stream advances only on a cycle where `elem_valid_o` and `elem_ready_i` are both high. While the stream is stalled, `elem_valid_o`, the address, the index and the length hold their values.
- R7: `done_o` is high for one cycle, in the cycle after the final element is accepted. It is never high together with `elem_valid_o`.
- R8: `start_i` is ignored while elements are still pending. The running sequence continues unchanged.
- R9: Address arithmetic wraps modulo 2^`ADDR_W` for both the start address and large strides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| base_i | input | ADDR_W | Address of element 0 |
| stride_i | input | ADDR_W | Address step between elements |
| total_i | input | CNT_W | Total element count |
| elem_ready_i | input | 1 | Consumer accepts the presented element |
| elem_valid_o | output | 1 | An element is presented |
| elem_addr_o | output | ADDR_W | Element address |
| elem_idx_o | output | IDX_W | Element index within its strip |
| strip_start_o | output | 1 | Presented element is the first of its strip |
| strip_len_o | output | LEN_W | Length of the current strip |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every output comes straight from a register. The first element therefore appears one cycle after the start edge, each handshake edge exposes the next element one cycle later, and the completion pulse follows the edge of the last handshake (or of a zero-count start) by one cycle. The bench keeps a model that updates at the same edges as the design, using only the inputs that were present at each edge. It compares every output against this model at the falling edge, when the outputs are stable. Strip lengths are also collected at accepted first-of-strip elements, after the inputs have settled. They are checked as whole lists for the counts that matter: a remainder, an exact multiple, and one beyond a multiple.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/strip_len_calc.sv
module strip_len_calc #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic [CNT_W-1:0] total_i,
  output logic [LEN_W-1:0] first_len_o
);
  logic [CNT_W-1:0] rem_w;

  always_comb begin
    rem_w       = total_i % CNT_W'(MAX_VL);
    first_len_o = (rem_w == '0) ? LEN_W'(MAX_VL) : LEN_W'(rem_w);
  end
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
    end else if (adv_i) begin
      addr_q   <= addr_q + stride_q;  // wraps modulo 2^ADDR_W
    end
  end

  assign addr_o = addr_q;

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !adv_i |=> $stable(addr_o));
endmodule

// File: rtl/strip_tracker.sv
module strip_tracker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1),
  parameter int unsigned IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [LEN_W-1:0] first_len_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic             strip_end;

  assign strip_end = (LEN_W'(idx_q) == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      idx_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      rem_q <= total_i;
      idx_q <= '0;
      len_q <= first_len_i;
    end else if (adv_i) begin
      rem_q <= rem_q - CNT_W'(1);
      if (strip_end) begin
        idx_q <= '0;
        len_q <= LEN_W'(MAX_VL);
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign idx_o  = idx_q;
  assign len_o  = len_q;
  assign last_o = (rem_q == CNT_W'(1));

  // R5
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o != '0 |-> LEN_W'(idx_o) < len_o);

  // R4
  full_strip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && strip_end && !last_o |=> len_o == LEN_W'(MAX_VL) && idx_o == '0);

  // R4
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= LEN_W'(MAX_VL));
endmodule

// File: rtl/strip_addr_seq.sv
module strip_addr_seq
  import strip_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned LEN_W = $clog2(MAX_VL + 1),
  localparam int unsigned IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic              elem_ready_i,
  output logic              elem_valid_o,
  output logic [ADDR_W-1:0] elem_addr_o,
  output logic [IDX_W-1:0]  elem_idx_o,
  output logic              strip_start_o,
  output logic [LEN_W-1:0]  strip_len_o,
  output logic              done_o
);
  seq_state_e       state_q;
  logic             done_q;
  logic             idle, load, zero_go, fire, last;
  logic [LEN_W-1:0] first_len;

  assign idle    = (state_q == ST_IDLE);
  assign load    = start_i && idle && (total_i != '0);
  assign zero_go = start_i && idle && (total_i == '0);
  assign fire    = (state_q == ST_RUN) && elem_ready_i;

  strip_len_calc #(.CNT_W(CNT_W), .MAX_VL(MAX_VL), .LEN_W(LEN_W)) i_len_calc (
    .total_i    (total_i),
    .first_len_o(first_len)
  );

  addr_stepper #(.ADDR_W(ADDR_W)) i_stepper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .base_i  (base_i),
    .stride_i(stride_i),
    .adv_i   (fire),
    .addr_o  (elem_addr_o)
  );

  strip_tracker #(.CNT_W(CNT_W), .MAX_VL(MAX_VL), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .total_i    (total_i),
    .first_len_i(first_len),
    .adv_i      (fire),
    .idx_o      (elem_idx_o),
    .len_o      (strip_len_o),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= zero_go || (fire && last);
      case (state_q)
        ST_IDLE: if (load) state_q <= ST_RUN;
        ST_RUN:  if (fire && last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign elem_valid_o  = (state_q == ST_RUN);
  assign strip_start_o = elem_valid_o && (elem_idx_o == '0);
  assign done_o        = done_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o && !elem_ready_i |=> elem_valid_o && $stable(elem_idx_o) && $stable(strip_len_o));

  // R7
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !elem_valid_o);

  // R2
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(elem_valid_o && elem_ready_i) || $past(start_i && total_i == '0));

  // R3
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(elem_valid_o) |-> $past(start_i) && elem_idx_o == '0);
endmodule

// File: tb/test_strip_addr_seq.sv
module test_strip_addr_seq;
  localparam int AW = 24, CW = 16, MV = 64, LW = 7, IW = 6;
  localparam int EW = AW + IW + LW;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0, elem_ready_i = 1'b1;
  logic [AW-1:0] base_i = '0, stride_i = '0;
  logic [CW-1:0] total_i = '0;
  logic          elem_valid_o, strip_start_o, done_o;
  logic [AW-1:0] elem_addr_o;
  logic [IW-1:0] elem_idx_o;
  logic [LW-1:0] strip_len_o;

  strip_addr_seq #(.ADDR_W(AW), .CNT_W(CW), .MAX_VL(MV)) i_strip_addr_seq (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0, ready_mode = 0;
  logic [EW-1:0] mq[$];
  bit m_done = 0;
  int len_log[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, advanced at each rising edge from the inputs alone
  always @(posedge clk_i) begin
    bit  was_act;
    int  first, idx, len;
    longint a;
    if (!rst_ni) begin
      mq.delete();
      m_done = 0;
    end else begin
      was_act = (mq.size() > 0);
      m_done  = 0;
      if (was_act && elem_ready_i) begin
        void'(mq.pop_front());
        if (mq.size() == 0) m_done = 1;
      end
      if (start_i && !was_act) begin
        if (total_i == 0) m_done = 1;
        else begin
          first = (int'(total_i) % MV == 0) ? MV : int'(total_i) % MV;
          for (int k = 0; k < int'(total_i); k++) begin
            if (k < first) begin idx = k; len = first; end
            else begin idx = (k - first) % MV; len = MV; end
            a = longint'(base_i) + longint'(k) * longint'(stride_i);
            mq.push_back({AW'(a), IW'(idx), LW'(len)});
          end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    bit ev;
    if (rst_ni) begin
      ev = (mq.size() > 0);
      chk(elem_valid_o == ev, "R3", "valid", elem_valid_o, ev);
      if (ev && elem_valid_o) begin
        chk(elem_addr_o == mq[0][EW-1 -: AW], "R3/R9", "addr", elem_addr_o, mq[0][EW-1 -: AW]);
        chk(elem_idx_o == mq[0][LW +: IW], "R5", "idx", elem_idx_o, mq[0][LW +: IW]);
        chk(strip_len_o == mq[0][LW-1:0], "R4", "strip_len", strip_len_o, mq[0][LW-1:0]);
        chk(strip_start_o == (mq[0][LW +: IW] == 0), "R5", "strip_start", strip_start_o,
            (mq[0][LW +: IW] == 0));
      end
      chk(done_o == m_done, "R2/R7", "done", done_o, m_done);
      if (done_o) chk(!elem_valid_o, "R7", "valid with done", elem_valid_o, 0);
    end
    #2;
    if (elem_valid_o && elem_ready_i && strip_start_o) len_log.push_back(int'(strip_len_o));
  end

  always @(negedge clk_i) begin
    #1;
    case (ready_mode)
      0: elem_ready_i <= 1'b1;
      1: elem_ready_i <= 1'($urandom % 2);
      default: elem_ready_i <= ~elem_ready_i;
    endcase
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [AW-1:0] b, input logic [AW-1:0] s, input int n,
                        input int mode, input bit inject);
    ready_mode = mode;
    len_log.delete();
    @(negedge clk_i); #1;
    start_i = 1'b1; base_i = b; stride_i = s; total_i = CW'(n);
    @(negedge clk_i); #1;
    start_i = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk_i);
      #1;
      // R8: a second request while busy must change nothing
      start_i = 1'b1; base_i = 24'h777777; stride_i = 24'h5; total_i = CW'(3);
      repeat (2) @(negedge clk_i);
      #1;
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_lens(input int exp[$], input string what);
    chk(len_log.size() == exp.size(), "R4", {what, " strip count"}, len_log.size(), exp.size());
    for (int i = 0; i < exp.size() && i < len_log.size(); i++)
      chk(len_log[i] == exp[i], "R4", {what, " strip length"}, len_log[i], exp[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(elem_valid_o == 1'b0, "R1", "valid in reset", elem_valid_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(elem_valid_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset", elem_valid_o, 0);

    run_op(24'h000010, 24'h1, 0, 0, 0);                 // R2
    chk(len_log.size() == 0, "R2", "no strip for zero count", len_log.size(), 0);
    run_op(24'h000100, 24'h1, 1, 0, 0);                 // R3 single element
    chk_lens('{1}, "n=1");
    run_op(24'h001000, 24'h4, 200, 1, 0);               // R4 R6 remainder first
    chk_lens('{8, 64, 64, 64}, "n=200");
    run_op(24'h002000, 24'h1, 128, 2, 0);               // R4 exact multiple
    chk_lens('{64, 64}, "n=128");
    run_op(24'h000000, 24'h3, 64, 0, 0);                // R4 one full strip
    chk_lens('{64}, "n=64");
    run_op(24'hFFFFF0, 24'h7, 65, 1, 0);                // R9 base wrap
    chk_lens('{1, 64}, "n=65");
    run_op(24'h000040, 24'h800001, 70, 2, 0);           // R9 large stride
    run_op(24'h010000, 24'h10, 150, 1, 1);              // R8 start while busy
    chk_lens('{22, 64, 64}, "n=150");
    run_op(24'h000020, 24'h2, 0, 1, 0);                 // R2 after activity
    run_op(24'h000300, 24'h20, 63, 0, 0);               // R4 remainder only
    chk_lens('{63}, "n=63");

    repeat (4) @(negedge clk_i);
    chk(elem_valid_o == 1'b0, "R7", "idle at end", elem_valid_o, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule